// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block buffers 9-bit words between a writer on one clock and a reader on an unrelated clock. Storage is a power-of-two array, 64 deep by default. The write and read pointers cross between the two domains in Gray code through two-stage synchronizers. Full and half-full are worked out on the write side. Empty and the fall-through output-ready state are worked out on the read side.

While master reset is held low, two pins are sampled. `mode_sel` picks the output timing:
- **Standard mode.** Every word, including the first, needs a read request. `rd_stat` is an active-low empty flag and `wr_stat` is an active-low full flag.
- **Fall-through mode.** The first word written into an empty FIFO shows on `rd_data` with no request. `rd_stat` is an active-low output-ready and `wr_stat` is an active-low input-ready.

`dflt_sel` picks one of two default thresholds for the almost-empty and almost-full flags. Later, a write-clock strobe can load new thresholds from the offset inputs. A partial reset empties the FIFO but keeps the mode and the thresholds.

Back-pressure rules:
- The writer may present a word on any write-clock edge. It must treat `wr_stat` as its ready signal: full flag high, or input-ready low.
- A write request made while the array is full is dropped and nothing is overwritten.
- The reader must only request while `rd_stat` shows data. A request made while empty is dropped and `rd_data` holds its last value.

Top module: `dcfifo_top`

## Requirements
- R1: The level of `mode_sel` while `mrst_n` is low selects the mode (0 = standard, 1 = fall-through). In reset, standard mode drives `rd_stat`=0 and `wr_stat`=1, and fall-through mode drives `rd_stat`=1 and `wr_stat`=0.
- R2: Either reset leaves the FIFO empty and drives `rd_data`=0, `alm_empty_n`=0, `alm_full_n`=1 and `half_n`=1.
- R3: A low pulse on `prst_n` keeps the latched mode and the current thresholds. A master reset reloads both from the pins.
- R4: A write request while the array holds DEPTH words is ignored. Stored words are neither overwritten nor added to.
- R5: A read request while no word is available leaves `rd_data` unchanged and the FIFO still empty.
- R6: In standard mode, each read edge with `rd_en_n` low moves the next word, in write order, onto `rd_data`. `rd_data` changes on that edge and on no other.
- R7: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_stat` low and no read request. Each read edge after that brings the next word.
- R8: `alm_empty_n` is 0 while the count of words in the storage array is below the empty threshold, and 1 otherwise. In fall-through mode, the word already on `rd_data` does not count.
- R9: `alm_full_n` is 0 while the free locations in the array (DEPTH minus count) are below the full threshold, and 1 otherwise.
- R10: `half_n` is 0 while the array holds more than DEPTH/2 words, and 1 otherwise.
- R11: `dflt_sel` during master reset sets both thresholds to DFLT_LO (0) or DFLT_HI (1), 7 and 15 by default. A write-clock edge with `ofs_wr` high loads `ofs_empty` and `ofs_full` as the new thresholds.
- R12: With the array full, `wr_stat` is 0 in standard mode and 1 in fall-through mode. In fall-through mode, one more word than DEPTH is accepted, because one word sits on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| mode_sel | input | 1 | Mode choice sampled during master reset |
| dflt_sel | input | 1 | Default threshold choice sampled during master reset |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | 9 | Write word |
| wr_stat | output | 1 | Full flag (standard) or input-ready (fall-through), active low |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | 9 | Output register |
| rd_stat | output | 1 | Empty flag (standard) or output-ready (fall-through), active low |
| ofs_wr | input | 1 | Threshold load strobe, write clock |
| ofs_empty | input | 7 | New almost-empty threshold |
| ofs_full | input | 7 | New almost-full threshold |
| half_n | output | 1 | Half-full flag, active low |
| alm_empty_n | output | 1 | Almost-empty flag, active low |
| alm_full_n | output | 1 | Almost-full flag, active low |

## Verification
The hardest state to reach from the ports is a completely full fall-through FIFO. There, DEPTH words sit in the array and one more sits in the output register, so the full status must appear only on the 65th write and not the 64th. The stimulus first lets a single word fall through, so that it is clear the output register is occupied. It then bursts writes with the reader idle, checks the status one word short of full and again at full, and then tries extra writes. Finally it drains all 65 words in order, to show that the dropped writes left no trace.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dcfifo_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, release aligned to the local clock.
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage <= 1'b0;
      rst_n <= 1'b0;
    end else begin
      stage <= 1'b1;
      rst_n <= stage;
    end
  end
endmodule

// File: rtl/dcfifo_gray_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded pointer.
module dcfifo_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_store.sv
`timescale 1ns/1ps
// Storage array: written on the write clock, read combinationally.
module dcfifo_store #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
`timescale 1ns/1ps
// Write side: pointer, full, half-full and almost-full.
module dcfifo_wr_ctrl #(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen_n,
  input  logic [AW:0]   rgray_s,
  input  logic [AW:0]   ofs_full,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic          full,
  output logic          half_n,
  output logic          afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] cnt_w;
  logic [PW-1:0] free_w;
  logic [PW-1:0] wbin_nx;

  assign rbin_s  = to_bin(rgray_s);
  assign cnt_w   = wbin - rbin_s;
  assign free_w  = PW'(DEPTH) - cnt_w;
  assign full    = (cnt_w == PW'(DEPTH));
  assign we      = !wen_n && !full;
  assign half_n  = !(cnt_w > PW'(HALF));
  assign afull_n = !(free_w < ofs_full);
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (wrst_n !== 1'b1)
    (full && !wen_n) |=> $stable(wbin));

  assert_count_bound_R4: assert property (@(posedge wclk) disable iff (wrst_n !== 1'b1)
    cnt_w <= PW'(DEPTH));

  assert_gray_one_bit_R12: assert property (@(posedge wclk) disable iff (wrst_n !== 1'b1)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_full_implies_half_R10: assert property (@(posedge wclk) disable iff (wrst_n !== 1'b1)
    full |-> !half_n);
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
`timescale 1ns/1ps
// Read side: pointer, output register, empty / output-ready and almost-empty.
module dcfifo_rd_ctrl #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren_n,
  input  logic          fwft,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  input  logic [AW:0]   ofs_empty,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          rd_stat,
  output logic          aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] cnt_r;
  logic [PW-1:0] rbin_nx;
  logic          empty;
  logic          ov;
  logic          take;
  logic          load;

  assign wbin_s  = to_bin(wgray_s);
  assign cnt_r   = wbin_s - rbin;
  assign empty   = (cnt_r == '0);
  assign rbin_nx = rbin + PW'(1);
  assign take    = fwft && ov && !ren_n;

  always_comb begin
    if (fwft) load = !empty && (!ov || take);
    else      load = !empty && !ren_n;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      dout  <= '0;
      ov    <= 1'b0;
    end else begin
      if (load) begin
        rbin  <= rbin_nx;
        rgray <= to_gray(rbin_nx);
        dout  <= mem_q;
      end
      ov <= fwft && (load || (ov && !take));
    end
  end

  assign rd_stat  = fwft ? !ov : !empty;
  assign aempty_n = !(cnt_r < ofs_empty);

  assert_rd_ignored_empty_R5: assert property (@(posedge rclk) disable iff (rrst_n !== 1'b1)
    (!fwft && empty && !ren_n) |=> ($stable(rbin) && $stable(dout)));

  assert_std_read_step_R6: assert property (@(posedge rclk) disable iff (rrst_n !== 1'b1)
    (!fwft && !empty && !ren_n) |=> (rbin == $past(rbin) + PW'(1)));

  assert_fall_through_R7: assert property (@(posedge rclk) disable iff (rrst_n !== 1'b1)
    (fwft && !ov && !empty) |=> ov);

  assert_occupancy_R8: assert property (@(posedge rclk) disable iff (rrst_n !== 1'b1)
    cnt_r <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_top.sv
`timescale 1ns/1ps
module dcfifo_top #(
  parameter int DW      = 9,
  parameter int AW      = 6,
  parameter int DFLT_LO = 7,
  parameter int DFLT_HI = 15
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          dflt_sel,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stat,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  input  logic          ofs_wr,
  input  logic [AW:0]   ofs_empty,
  input  logic [AW:0]   ofs_full,
  output logic          half_n,
  output logic          alm_empty_n,
  output logic          alm_full_n
);
  import dcfifo_pkg::*;

  localparam int PW = AW + 1;

  logic          arst_n;
  logic          wrst_n;
  logic          rrst_n;
  fifo_mode_e    mode_q;
  logic [PW-1:0] thr_empty;
  logic [PW-1:0] thr_full;
  logic [PW-1:0] wbin, wgray, wgray_s;
  logic [PW-1:0] rbin, rgray, rgray_s;
  logic          we;
  logic          full;
  logic [DW-1:0] mem_q;

  assign arst_n = mrst_n & prst_n;

  // Configuration survives partial reset; loaded only during master reset.
  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      mode_q    <= fifo_mode_e'(mode_sel);
      thr_empty <= dflt_sel ? PW'(DFLT_HI) : PW'(DFLT_LO);
      thr_full  <= dflt_sel ? PW'(DFLT_HI) : PW'(DFLT_LO);
    end else if (ofs_wr) begin
      thr_empty <= ofs_empty;
      thr_full  <= ofs_full;
    end
  end

  dcfifo_rst_sync u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n(wrst_n));
  dcfifo_rst_sync u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n(rrst_n));

  dcfifo_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  dcfifo_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcfifo_store #(.DW(DW), .AW(AW)) u_store (
    .wclk  (wclk),
    .we    (we),
    .waddr (wbin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rbin[AW-1:0]),
    .rdata (mem_q)
  );

  dcfifo_wr_ctrl #(.AW(AW)) u_wr (
    .wclk     (wclk),
    .wrst_n   (wrst_n),
    .wen_n    (wr_en_n),
    .rgray_s  (rgray_s),
    .ofs_full (thr_full),
    .wbin     (wbin),
    .wgray    (wgray),
    .we       (we),
    .full     (full),
    .half_n   (half_n),
    .afull_n  (alm_full_n)
  );

  dcfifo_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk      (rclk),
    .rrst_n    (rrst_n),
    .ren_n     (rd_en_n),
    .fwft      (mode_q == MODE_FWFT),
    .wgray_s   (wgray_s),
    .mem_q     (mem_q),
    .ofs_empty (thr_empty),
    .rbin      (rbin),
    .rgray     (rgray),
    .dout      (rd_data),
    .rd_stat   (rd_stat),
    .aempty_n  (alm_empty_n)
  );

  // Full flag is active low in standard mode; input-ready is active low in fall-through.
  assign wr_stat = (mode_q == MODE_FWFT) ? full : !full;
endmodule

// File: tb/dcfifo_top_test.sv
`timescale 1ns/1ps
module dcfifo_top_test;
  logic       wclk = 1'b0;
  logic       rclk = 1'b0;
  logic       mrst_n = 1'b0;
  logic       prst_n = 1'b1;
  logic       mode_sel = 1'b0;
  logic       dflt_sel = 1'b0;
  logic       wr_en_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic       rd_en_n = 1'b1;
  logic       ofs_wr = 1'b0;
  logic [6:0] ofs_empty = '0;
  logic [6:0] ofs_full = '0;
  logic       wr_stat, rd_stat, half_n, alm_empty_n, alm_full_n;
  logic [8:0] rd_data;

  int checks = 0;
  int failures = 0;
  int wseq = 0;
  int rseq = 0;
  logic [8:0] held;

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dcfifo_top uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .dflt_sel(dflt_sel),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_stat(wr_stat),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_stat(rd_stat),
    .ofs_wr(ofs_wr), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
    .half_n(half_n), .alm_empty_n(alm_empty_n), .alm_full_n(alm_full_n)
  );

  // {read, count[6:0], alm_empty_n, alm_full_n, half_n, wr_stat, rd_stat}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 7'd3,  5'b01111},
    {1'b0, 7'd4,  5'b11111},
    {1'b0, 7'd26, 5'b11011},
    {1'b1, 7'd1,  5'b11111},
    {1'b0, 7'd26, 5'b10011},
    {1'b0, 7'd1,  5'b10011},
    {1'b0, 7'd5,  5'b10001},
    {1'b1, 7'd64, 5'b01110}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic wr_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en_n = 1'b0;
      wr_data = 9'(wseq);
      wseq++;
    end
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic wr_junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en_n = 1'b0;
      wr_data = 9'h1AA;
    end
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_pulse();
    @(negedge rclk);
    rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1;
  endtask

  task automatic std_read(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rd_pulse();
      check(req, rd_data, rseq & 511);
      rseq++;
    end
  endtask

  task automatic fwft_read(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, rd_data, rseq & 511);
      rd_pulse();
      rseq++;
    end
  endtask

  task automatic master(input logic m, input logic d);
    @(negedge wclk);
    mrst_n = 1'b0;
    mode_sel = m;
    dflt_sel = d;
    repeat (4) @(negedge rclk);
    mrst_n = 1'b1;
    rseq = wseq;
    settle();
  endtask

  task automatic partial();
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (4) @(negedge rclk);
    prst_n = 1'b1;
    rseq = wseq;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Power-up master reset, standard mode, low defaults
    repeat (4) @(negedge rclk);
    mrst_n = 1'b1;
    settle();
    check("R1 std rd_stat", rd_stat, 0);
    check("R1 std wr_stat", wr_stat, 1);
    check("R2 rd_data", rd_data, 0);
    check("R2 alm_empty_n", alm_empty_n, 0);
    check("R2 alm_full_n", alm_full_n, 1);
    check("R2 half_n", half_n, 1);

    // Table walk in standard mode, thresholds 7/7 (R6 R8 R9 R10 R12)
    foreach (VEC[i]) begin
      if (VEC[i][12]) std_read(int'(VEC[i][11:5]), "R6 data");
      else            wr_burst(int'(VEC[i][11:5]));
      settle();
      check("R8 alm_empty_n", alm_empty_n, VEC[i][4]);
      check("R9 alm_full_n",  alm_full_n,  VEC[i][3]);
      check("R10 half_n",     half_n,      VEC[i][2]);
      check("R12 wr_stat",    wr_stat,     VEC[i][1]);
      check("R6 rd_stat",     rd_stat,     VEC[i][0]);
    end

    // R4: writes while full are dropped
    wr_burst(64);
    settle();
    check("R12 std full flag", wr_stat, 0);
    wr_junk(3);
    settle();
    std_read(64, "R4 data order");
    settle();
    check("R4 empty after drain", rd_stat, 0);

    // R5: read while empty holds data
    held = rd_data;
    rd_pulse();
    settle();
    check("R5 rd_data held", rd_data, held);
    check("R5 still empty", rd_stat, 0);

    // R11: load thresholds 20 / 10
    @(negedge wclk);
    ofs_wr = 1'b1; ofs_empty = 7'd20; ofs_full = 7'd10;
    @(negedge wclk);
    ofs_wr = 1'b0;
    wr_burst(19);
    settle();
    check("R11 below loaded threshold", alm_empty_n, 0);
    wr_burst(1);
    settle();
    check("R11 at loaded threshold", alm_empty_n, 1);

    // R3: partial reset keeps mode and thresholds
    partial();
    check("R2 prst rd_data", rd_data, 0);
    check("R3 mode kept rd_stat", rd_stat, 0);
    check("R3 mode kept wr_stat", wr_stat, 1);
    check("R2 prst alm_empty_n", alm_empty_n, 0);
    check("R2 prst alm_full_n", alm_full_n, 1);
    check("R2 prst half_n", half_n, 1);
    wr_burst(19);
    settle();
    check("R3 threshold kept (19)", alm_empty_n, 0);
    wr_burst(1);
    settle();
    check("R3 threshold kept (20)", alm_empty_n, 1);
    wr_burst(34);
    settle();
    check("R9 free=10", alm_full_n, 1);
    wr_burst(1);
    settle();
    check("R9 free=9", alm_full_n, 0);
    check("R10 count 55", half_n, 0);

    // Master reset into fall-through, high defaults
    master(1'b1, 1'b1);
    check("R1 fwft rd_stat", rd_stat, 1);
    check("R1 fwft wr_stat", wr_stat, 0);
    check("R2 mrst rd_data", rd_data, 0);
    check("R2 mrst alm_empty_n", alm_empty_n, 0);
    check("R2 mrst alm_full_n", alm_full_n, 1);
    check("R2 mrst half_n", half_n, 1);

    wr_burst(1);
    settle();
    check("R7 ready without read", rd_stat, 0);
    check("R7 first word shown", rd_data, rseq & 511);
    check("R8 shown word not counted", alm_empty_n, 0);
    wr_burst(14);
    settle();
    check("R11 default hi, 14 stored", alm_empty_n, 0);
    wr_burst(1);
    settle();
    check("R3 mrst reloads threshold, 15 stored", alm_empty_n, 1);
    fwft_read(16, "R7 data");
    settle();
    check("R7 not ready after drain", rd_stat, 1);
    held = rd_data;
    rd_pulse();
    settle();
    check("R5 fwft rd_data held", rd_data, held);
    check("R5 fwft still not ready", rd_stat, 1);

    // R12: fall-through holds DEPTH+1 words
    wr_burst(64);
    settle();
    check("R12 room after 64", wr_stat, 0);
    wr_burst(1);
    settle();
    check("R12 full after 65", wr_stat, 1);
    wr_junk(2);
    settle();
    fwft_read(65, "R4 fwft data order");
    settle();
    check("R4 fwft empty after drain", rd_stat, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule